// File: doc/BRIEF.md
# DRAM DLL State Tracker and Command Guard

This block sits on the controller side of a DDR3-class memory interface. It follows the memory device's DLL state from the decoded command stream the controller sends and from the clock-enable level. Mode-register writes to the first and second mode registers update shadow copies of the DLL-disable bit, the nominal termination field and the write termination field. A DLL reset issued while the DLL is enabled starts a lock wait of `LOCK_CYC` clock cycles. Self-refresh entry stops an enabled DLL, and self-refresh exit restarts the same lock wait.

The output `rd_ready` tells the scheduler when reads and synchronous ODT may be issued. Commands that break a DLL rule set their own sticky bit in `err`. The rules cover early reads or ODT, a low clock enable during the lock wait, writes with write termination while the DLL is off, termination driven while the DLL is off, and dynamic termination left programmed while the DLL is off. A one-cycle `err_clr` pulse clears the bits. The block only observes the command stream. It never blocks or reorders commands.

Command codes on `cmd_code`: NOP=0, MRS=1, DLL reset=2, self-refresh entry=3, self-refresh exit=4, READ=5, WRITE=6. Error bit positions: 0 clock enable low during lock wait, 1 early read, 2 early ODT, 3 write with write termination while DLL-off, 4 termination driven while DLL-off, 5 dynamic termination programmed while DLL-off.

Top module: `dll_guard`

## Requirements
- R1: While `rst_n` is low and after it is released, `dll_off_mode`=1, `rd_ready`=0, `in_sref`=0, `err`=0, `rtt_nom`=0 and `rtt_wr`=0.
- R2: An MRS (code 1) with `mrs_sel`=1 loads `rtt_nom` from address bits {A9,A6,A2} (A2 is the LSB) and sets `dll_off_mode` to A0. With `mrs_sel`=2 it loads `rtt_wr` from {A10,A9} (A9 is the LSB). Any other `mrs_sel` value changes nothing, and an MRS issued during self-refresh changes nothing.
- R3: After a DLL reset (code 2) that arrives while the DLL is enabled and outside self-refresh, `rd_ready` is low for the next LOCK_CYC-1 edges and is high after edge LOCK_CYC-1, so a READ sampled LOCK_CYC edges after the reset raises no error. A DLL reset in DLL-off mode leaves `rd_ready` low.
- R4: A READ (code 5), or `odt` high, on an edge where the DLL is enabled but the lock wait has not finished (including before the first DLL reset) sets `err[1]` or `err[2]` respectively.
- R5: `cke` low on an edge during the lock wait sets `err[0]`.
- R6: Self-refresh entry (code 3) with the DLL enabled sets `in_sref` and drops `rd_ready` after that edge. Self-refresh exit (code 4) clears `in_sref` and restarts the lock wait with the timing of R3.
- R7: A WRITE (code 6) in DLL-off mode with `rtt_wr` non-zero sets `err[3]`. With `rtt_wr`=0 it sets nothing.
- R8: `odt` high in DLL-off mode with `rtt_nom` non-zero sets `err[4]`. With `rtt_nom`=0 it sets nothing.
- R9: Any cycle in DLL-off mode with `rtt_wr` non-zero sets `err[5]` on the following edge.
- R10: Error bits hold until `err_clr` is sampled high, which clears every bit. A violation sampled on the same edge as the clear still sets its bit.
- R11: An MR1 write with A0=0 taken from DLL-off mode clears `dll_off_mode` but keeps `rd_ready` low until a DLL reset and its lock wait. An MR1 write with A0=0 while locked leaves `rd_ready` high. An MR1 write with A0=1 drops `rd_ready` after its edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_code | input | 3 | Decoded command for this cycle |
| mrs_sel | input | 2 | Mode register targeted by an MRS |
| mrs_addr | input | ADDR_W | Address bits carried by an MRS |
| odt | input | 1 | ODT pin level sent to the device |
| cke | input | 1 | Clock-enable level sent to the device |
| err_clr | input | 1 | Clears all sticky error bits |
| rd_ready | output | 1 | Reads and synchronous ODT allowed |
| dll_off_mode | output | 1 | Device is in DLL-off mode |
| in_sref | output | 1 | Device is in self-refresh |
| rtt_nom | output | 3 | Shadow of the nominal termination field |
| rtt_wr | output | 2 | Shadow of the write termination field |
| err | output | 6 | Sticky rule-violation bits |

## Verification
On every cycle the assertions check these relations: each rule violation sets its error bit one edge later, error bits never fall without a clear, self-refresh entry drops readiness, and readiness rises only when a lock wait ends. Only the directed scenarios can show the exact length of the lock window at both of its edges, the mapping of address bits into the shadow fields, that MRS writes are ignored during self-refresh, and the mode sequences of R11.

// File: rtl/dllg_pkg.sv
// Package: shared command codes, tracker states and error bit indices
// for the DLL state tracker. Assumes commands arrive already decoded.
package dllg_pkg;

    typedef enum logic [2:0] {
        CMD_NOP    = 3'd0,
        CMD_MRS    = 3'd1,
        CMD_DLLRST = 3'd2,
        CMD_SRE    = 3'd3,
        CMD_SRX    = 3'd4,
        CMD_READ   = 3'd5,
        CMD_WRITE  = 3'd6
    } dllg_cmd_e;

    typedef enum logic [2:0] {
        ST_OFF      = 3'd0,
        ST_WAITRST  = 3'd1,
        ST_LOCKING  = 3'd2,
        ST_LOCKED   = 3'd3,
        ST_SREF     = 3'd4
    } dllg_state_e;

    localparam int ERR_N        = 6;
    localparam int ERR_CKE      = 0;
    localparam int ERR_RD_EARLY = 1;
    localparam int ERR_ODT_EARLY= 2;
    localparam int ERR_WR_OFF   = 3;
    localparam int ERR_ODT_OFF  = 4;
    localparam int ERR_DYN_OFF  = 5;

    localparam logic [1:0] SEL_MR1 = 2'd1;
    localparam logic [1:0] SEL_MR2 = 2'd2;

endpackage

// File: rtl/dllg_shadow.sv
// Module: dllg_shadow
// Holds shadow copies of the termination fields written by MRS commands.
// Assumes the caller gates mrs_fire off during self-refresh.
module dllg_shadow
    import dllg_pkg::*;
#(
    parameter int ADDR_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mrs_fire,
    input  logic [1:0]        mrs_sel,
    input  logic [ADDR_W-1:0] mrs_addr,
    output logic [2:0]        rtt_nom,
    output logic [1:0]        rtt_wr
);
    localparam int A_NOM0 = 2;
    localparam int A_NOM1 = 6;
    localparam int A_NOM2 = 9;
    localparam int A_WR0  = 9;
    localparam int A_WR1  = 10;

    // Capture the addressed field on an MRS to MR1 or MR2.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rtt_nom <= '0;
            rtt_wr  <= '0;
        end else if (mrs_fire) begin
            if (mrs_sel == SEL_MR1)
                rtt_nom <= {mrs_addr[A_NOM2], mrs_addr[A_NOM1], mrs_addr[A_NOM0]};
            if (mrs_sel == SEL_MR2)
                rtt_wr  <= {mrs_addr[A_WR1], mrs_addr[A_WR0]};
        end
    end

endmodule

// File: rtl/dllg_lock.sv
// Module: dllg_lock
// DLL state machine with the lock-wait counter and the self-refresh flag.
// Assumes LOCK_CYC >= 2; readiness is high once LOCK_CYC-1 edges have
// passed since the DLL reset or self-refresh exit.
module dllg_lock
    import dllg_pkg::*;
#(
    parameter int LOCK_CYC = 512
) (
    input  logic        clk,
    input  logic        rst_n,
    input  dllg_cmd_e   cmd,
    input  logic        mr1_fire,
    input  logic        mr1_a0,
    output dllg_state_e state,
    output logic        in_sref,
    output logic        rd_ready,
    output logic        lock_busy,
    output logic        unlocked
);
    localparam int CNT_W = (LOCK_CYC > 2) ? $clog2(LOCK_CYC) : 1;
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(LOCK_CYC - 2);

    dllg_state_e      state_n;
    logic [CNT_W-1:0] cnt, cnt_n;
    logic             sref_n;

    // Next-state: countdown by default, commands override it.
    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        sref_n  = in_sref;
        if (state == ST_LOCKING) begin
            if (cnt == '0) state_n = ST_LOCKED;
            else           cnt_n   = cnt - 1'b1;
        end
        unique case (cmd)
            CMD_SRE: if (!in_sref) begin
                sref_n = 1'b1;
                if (state != ST_OFF) state_n = ST_SREF;
            end
            CMD_SRX: if (in_sref) begin
                sref_n = 1'b0;
                if (state == ST_SREF) begin
                    state_n = ST_LOCKING;
                    cnt_n   = LOAD;
                end
            end
            CMD_DLLRST: if (state == ST_WAITRST || state == ST_LOCKING ||
                            state == ST_LOCKED) begin
                state_n = ST_LOCKING;
                cnt_n   = LOAD;
            end
            CMD_MRS: if (mr1_fire) begin
                if (mr1_a0)                state_n = ST_OFF;
                else if (state == ST_OFF)  state_n = ST_WAITRST;
            end
            default: ;
        endcase
    end

    // State, counter and self-refresh registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_OFF;
            cnt     <= '0;
            in_sref <= 1'b0;
        end else begin
            state   <= state_n;
            cnt     <= cnt_n;
            in_sref <= sref_n;
        end
    end

    // Status decode for the rule checker and the port.
    always_comb begin
        rd_ready  = (state == ST_LOCKED);
        lock_busy = (state == ST_LOCKING);
        unlocked  = (state == ST_LOCKING) || (state == ST_WAITRST);
    end

endmodule

// File: rtl/dllg_rules.sv
// Module: dllg_rules
// Detects DLL rule violations each cycle and keeps one sticky bit per rule.
// Assumes its inputs are the registered tracker state of this cycle.
module dllg_rules
    import dllg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  dllg_cmd_e        cmd,
    input  logic             odt,
    input  logic             cke,
    input  logic             clr,
    input  logic             off_mode,
    input  logic             unlocked,
    input  logic             lock_busy,
    input  logic [2:0]       rtt_nom,
    input  logic [1:0]       rtt_wr,
    output logic [ERR_N-1:0] err
);
    logic [ERR_N-1:0] ev;

    // Violation events for this cycle.
    always_comb begin
        ev                = '0;
        ev[ERR_CKE]       = lock_busy && !cke;
        ev[ERR_RD_EARLY]  = unlocked && (cmd == CMD_READ);
        ev[ERR_ODT_EARLY] = unlocked && odt;
        ev[ERR_WR_OFF]    = off_mode && (cmd == CMD_WRITE) && (|rtt_wr);
        ev[ERR_ODT_OFF]   = off_mode && odt && (|rtt_nom);
        ev[ERR_DYN_OFF]   = off_mode && (|rtt_wr);
    end

    // One sticky flag per rule; a new event outranks the clear.
    for (genvar i = 0; i < ERR_N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n) err[i] <= 1'b0;
            else        err[i] <= (err[i] & ~clr) | ev[i];
        end
    end

endmodule

// File: rtl/dll_guard.sv
// Module: dll_guard (top)
// Tracks the device DLL from decoded commands, gates reads and ODT with
// rd_ready and flags rule violations. Assumes one command per cycle and
// that MRS writes during self-refresh are to be ignored.
module dll_guard
    import dllg_pkg::*;
#(
    parameter int ADDR_W   = 14,
    parameter int LOCK_CYC = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cmd_code,
    input  logic [1:0]        mrs_sel,
    input  logic [ADDR_W-1:0] mrs_addr,
    input  logic              odt,
    input  logic              cke,
    input  logic              err_clr,
    output logic              rd_ready,
    output logic              dll_off_mode,
    output logic              in_sref,
    output logic [2:0]        rtt_nom,
    output logic [1:0]        rtt_wr,
    output logic [ERR_N-1:0]  err
);
    dllg_cmd_e   cmd;
    dllg_state_e state;
    logic        mrs_fire, mr1_fire, lock_busy, unlocked;

    // Command decode and MRS gating.
    always_comb begin
        cmd          = dllg_cmd_e'(cmd_code);
        mrs_fire     = (cmd == CMD_MRS) && !in_sref;
        mr1_fire     = mrs_fire && (mrs_sel == SEL_MR1);
        dll_off_mode = (state == ST_OFF);
    end

    dllg_shadow #(.ADDR_W(ADDR_W)) u_shadow (
        .clk(clk), .rst_n(rst_n), .mrs_fire(mrs_fire), .mrs_sel(mrs_sel),
        .mrs_addr(mrs_addr), .rtt_nom(rtt_nom), .rtt_wr(rtt_wr)
    );

    dllg_lock #(.LOCK_CYC(LOCK_CYC)) u_lock (
        .clk(clk), .rst_n(rst_n), .cmd(cmd), .mr1_fire(mr1_fire),
        .mr1_a0(mrs_addr[0]), .state(state), .in_sref(in_sref),
        .rd_ready(rd_ready), .lock_busy(lock_busy), .unlocked(unlocked)
    );

    dllg_rules u_rules (
        .clk(clk), .rst_n(rst_n), .cmd(cmd), .odt(odt), .cke(cke),
        .clr(err_clr), .off_mode(dll_off_mode), .unlocked(unlocked),
        .lock_busy(lock_busy), .rtt_nom(rtt_nom), .rtt_wr(rtt_wr), .err(err)
    );

endmodule

// File: rtl/dll_guard_chk.sv
// Module: dll_guard_chk
// Property checker bound to dll_guard; observes ports and the lock-wait flag.
module dll_guard_chk
    import dllg_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] cmd_code,
    input logic       odt,
    input logic       cke,
    input logic       err_clr,
    input logic       rd_ready,
    input logic       dll_off_mode,
    input logic       in_sref,
    input logic [2:0] rtt_nom,
    input logic [1:0] rtt_wr,
    input logic [5:0] err,
    input logic       lock_busy
);
    AST_RDY_FROM_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_ready) |-> $past(lock_busy)); // R3
    AST_OFF_RST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_code == CMD_DLLRST && dll_off_mode) |=> !rd_ready); // R3
    AST_EARLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_code == CMD_READ && !dll_off_mode && !rd_ready && !in_sref) |=> err[1]); // R4
    AST_CKE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_busy && !cke) |=> err[0]); // R5
    AST_SREF_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_code == CMD_SRE && !in_sref) |=> (in_sref && !rd_ready)); // R6
    AST_WR_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_code == CMD_WRITE && dll_off_mode && rtt_wr != 2'b00) |=> err[3]); // R7
    AST_ODT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (odt && dll_off_mode && rtt_nom != 3'b000) |=> err[4]); // R8
    AST_DYN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (dll_off_mode && rtt_wr != 2'b00) |=> err[5]); // R9
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !err_clr |=> ((err & $past(err)) == $past(err))); // R10
endmodule

bind dll_guard dll_guard_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_code(cmd_code), .odt(odt), .cke(cke),
    .err_clr(err_clr), .rd_ready(rd_ready), .dll_off_mode(dll_off_mode),
    .in_sref(in_sref), .rtt_nom(rtt_nom), .rtt_wr(rtt_wr), .err(err),
    .lock_busy(lock_busy)
);

// File: tb/dll_guard_test.sv
// Directed bench for dll_guard: one task per scenario, each checking itself.
module dll_guard_test;
    localparam int L = 8;
    localparam int AW = 14;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    cmd_code = 3'd0;
    logic [1:0]    mrs_sel = 2'd0;
    logic [AW-1:0] mrs_addr = '0;
    logic          odt = 1'b0, cke = 1'b1, err_clr = 1'b0;
    logic          rd_ready, dll_off_mode, in_sref;
    logic [2:0]    rtt_nom;
    logic [1:0]    rtt_wr;
    logic [5:0]    err;
    int            n_chk = 0, n_fail = 0;

    always #2.5 clk = ~clk;

    dll_guard #(.ADDR_W(AW), .LOCK_CYC(L)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_code(cmd_code), .mrs_sel(mrs_sel),
        .mrs_addr(mrs_addr), .odt(odt), .cke(cke), .err_clr(err_clr),
        .rd_ready(rd_ready), .dll_off_mode(dll_off_mode), .in_sref(in_sref),
        .rtt_nom(rtt_nom), .rtt_wr(rtt_wr), .err(err)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        check(act === exp, tag, act, exp);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic issue(input logic [2:0] c, input logic [1:0] s = 2'd0,
                         input logic [AW-1:0] a = '0);
        cmd_code = c; mrs_sel = s; mrs_addr = a;
        @(negedge clk);
        cmd_code = 3'd0; mrs_sel = 2'd0; mrs_addr = '0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; cmd_code = 3'd0; odt = 1'b0; cke = 1'b1; err_clr = 1'b0;
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic clear_err();
        err_clr = 1'b1; @(negedge clk); err_clr = 1'b0;
    endtask

    task automatic lock_up();
        issue(3'd1, 2'd1, '0);
        issue(3'd2);
        idle(L - 1);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; idle(2);
        chk_eq("R1 ready in reset", rd_ready, 0);
        chk_eq("R1 off in reset", dll_off_mode, 1);
        rst_n = 1'b1; @(negedge clk);
        chk_eq("R1 err after reset", err, 0);
        chk_eq("R1 sref after reset", in_sref, 0);
        chk_eq("R1 shadows after reset", {rtt_nom, rtt_wr}, 0);
    endtask

    task automatic t_shadow();
        do_reset();
        issue(3'd1, 2'd1, AW'((1 << 9) | (1 << 6) | 1));
        chk_eq("R2 rtt_nom capture", rtt_nom, 3'b110);
        chk_eq("R2 A0 keeps off mode", dll_off_mode, 1);
        issue(3'd1, 2'd2, AW'(1 << 10));
        chk_eq("R2 rtt_wr capture", rtt_wr, 2'b10);
        issue(3'd1, 2'd3, '1);
        issue(3'd1, 2'd0, '1);
        chk_eq("R2 other selector ignored", {rtt_nom, rtt_wr, dll_off_mode}, {3'b110, 2'b10, 1'b1});
        do_reset(); lock_up();
        issue(3'd3);
        issue(3'd1, 2'd1, AW'(1 | (1 << 2)));
        issue(3'd4);
        chk_eq("R2 MRS in self-refresh ignored", {dll_off_mode, rtt_nom}, 0);
    endtask

    task automatic t_lock_timing();
        do_reset();
        issue(3'd1, 2'd1, '0);
        chk_eq("R11 enable clears off mode", dll_off_mode, 0);
        issue(3'd2);
        idle(L - 2);
        chk_eq("R3 not ready at L-2", rd_ready, 0);
        idle(1);
        chk_eq("R3 ready after L-1", rd_ready, 1);
        issue(3'd5);
        chk_eq("R3 read at edge L accepted", err, 0);
        issue(3'd2);
        chk_eq("R3 reset drops ready", rd_ready, 0);
        idle(L - 2);
        issue(3'd5);
        chk_eq("R3 read at edge L-1 flagged", err, 6'b000010);
        do_reset();
        issue(3'd2);
        idle(L);
        chk_eq("R3 reset ignored in off mode", rd_ready, 0);
    endtask

    task automatic t_early();
        do_reset();
        issue(3'd1, 2'd1, '0);
        issue(3'd5);
        chk_eq("R4 read before DLL reset", err, 6'b000010);
        clear_err();
        odt = 1'b1; @(negedge clk); odt = 1'b0;
        chk_eq("R4 odt before lock", err, 6'b000100);
    endtask

    task automatic t_cke();
        do_reset();
        issue(3'd1, 2'd1, '0);
        issue(3'd2);
        idle(1);
        cke = 1'b0; @(negedge clk); cke = 1'b1;
        chk_eq("R5 cke low in lock wait", err, 6'b000001);
        idle(L);
        chk_eq("R5 lock completes", rd_ready, 1);
    endtask

    task automatic t_sref();
        do_reset(); lock_up();
        issue(3'd3);
        chk_eq("R6 sre state", {in_sref, rd_ready, dll_off_mode}, 3'b100);
        idle(3);
        issue(3'd4);
        chk_eq("R6 srx clears sref", {in_sref, rd_ready}, 2'b00);
        idle(L - 2);
        chk_eq("R6 not ready at L-2 after exit", rd_ready, 0);
        idle(1);
        chk_eq("R6 ready after exit wait", rd_ready, 1);
        chk_eq("R6 no errors", err, 0);
    endtask

    task automatic t_offwrite();
        do_reset();
        issue(3'd6);
        chk_eq("R7 write with rtt_wr 0 allowed", err, 0);
        issue(3'd1, 2'd2, AW'(1 << 9));
        chk_eq("R9 rtt_wr shadow", rtt_wr, 2'b01);
        idle(1);
        chk_eq("R9 dynamic termination in off mode", err, 6'b100000);
        issue(3'd6);
        chk_eq("R7 write with rtt_wr set", err, 6'b101000);
    endtask

    task automatic t_offodt();
        do_reset();
        issue(3'd1, 2'd1, AW'(1));
        odt = 1'b1; @(negedge clk); odt = 1'b0;
        chk_eq("R8 odt with rtt_nom 0 allowed", err, 0);
        issue(3'd1, 2'd1, AW'(1 | (1 << 2)));
        odt = 1'b1; @(negedge clk); odt = 1'b0;
        chk_eq("R8 odt with rtt_nom set", err, 6'b010000);
    endtask

    task automatic t_sticky();
        do_reset();
        issue(3'd1, 2'd1, '0);
        issue(3'd5);
        idle(4);
        chk_eq("R10 bit holds", err, 6'b000010);
        clear_err();
        chk_eq("R10 clear", err, 0);
        issue(3'd5);
        err_clr = 1'b1; odt = 1'b1; @(negedge clk); err_clr = 1'b0; odt = 1'b0;
        chk_eq("R10 event wins over clear", err, 6'b000100);
    endtask

    task automatic t_mode_switch();
        do_reset(); lock_up();
        issue(3'd1, 2'd1, '0);
        chk_eq("R11 re-enable keeps ready", rd_ready, 1);
        issue(3'd1, 2'd1, AW'(1));
        chk_eq("R11 disable drops ready", {rd_ready, dll_off_mode}, 2'b01);
        issue(3'd1, 2'd1, '0);
        idle(L);
        chk_eq("R11 waits for DLL reset", {rd_ready, dll_off_mode}, 2'b00);
    endtask

    initial begin
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL watchdog R1..all actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_shadow();
        t_lock_timing();
        t_early();
        t_cke();
        t_sref();
        t_offwrite();
        t_offodt();
        t_sticky();
        t_mode_switch();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule